// File: doc/BRIEF.md
# Indexed Register Host-Port Slave

This block connects an asynchronous host bus to a small internal register file through two I/O ports. An index port holds an 8-bit register number. A data port then reads or writes the register selected by that number. A six-bit slice of the host address, bits [9:4], is matched against one of eight base addresses from 0x300 to 0x370. The eight candidates are spaced 0x10 apart, and the choice among them comes from a select input. A command-type input separates the two ports: low selects the index port at base+0, and high selects the data port at base+4.

The read and write strobes cross into the core clock through a two-flop synchronizer. A write takes effect when the synchronized strobe goes inactive. A read pulls the wait output low for a fixed two cycles and releases it once the return data is registered. At the first clock after reset two width straps are sampled, together with the strobe-polarity and interrupt-polarity configuration inputs. These values stay fixed until the next reset. The sampled width masks data-port values, drives the word-access indication, and is reported in a status register. A stub interrupt source sets a pending bit, and that bit drives the interrupt output.

Top module: `idx_host_slave`

## Requirements
- R1: A cycle is accepted only when `host_addr_i[5:3]` (address bits [9:7]) equals 3'b110 and `host_addr_i[2:0]` equals `base_sel_i`; `base_sel_i`=0 places the ports at 0x300/0x304, and a non-matching address has no effect on any register.
- R2: While `host_csn_i` is high no cycle is accepted, `host_word_n_o` stays high and `host_doe_o` stays low.
- R3: With `host_cmd_i`=0 a write loads `host_din_i[7:0]` into the index and a read returns the index; with `host_cmd_i`=1 reads and writes target the register selected by the index (indices 0 to 15 are storage).
- R4: With `cfg_strobe_inv_i`=0 at reset release the strobes are active low; with 1 they are active high.
- R5: Width straps {`strap_wake_i`,`strap_eedo_i`}: 00 = 16-bit, 01 = 32-bit, 10 = 8-bit, 11 (reserved) = 8-bit; data-port writes store and reads return the value zero-extended from the active width.
- R6: Register 0xFE reads {width code in bits [7:6], zero bits [5:1], interrupt pending in bit 0}; the width code is 00 for 16-bit, 01 for 32-bit and 10 for 8-bit, including the reserved strap setting.
- R7: A selected read pulls `host_waitn_o` low on the third clock edge after the strobe becomes active and holds it low for exactly two cycles; `host_dout_o` holds the read value from the release onward.
- R8: A write commits after the synchronized strobe goes inactive, using the address, command and data captured while it was active.
- R9: `host_word_n_o` is low while a selected data-port access (`host_cmd_i`=1) is presented in 16- or 32-bit mode, and high for 8-bit mode and for the index port.
- R10: A high `irq_src_i` sets the pending bit; writing 1 to bit 0 of 0xFE clears it; `irq_o` equals the pending bit, inverted when `cfg_irq_inv_i` was 1 at reset release.
- R11: Strap and configuration inputs are sampled once after reset; later changes have no effect until the next reset.
- R12: Indices 16 to 0xFD and 0xFF read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_addr_i | input | 6 | Host address bits [9:4] |
| host_csn_i | input | 1 | Address enable, active low |
| host_cmd_i | input | 1 | Command type: 0 index port, 1 data port |
| host_rd_i | input | 1 | Read strobe, polarity per configuration |
| host_wr_i | input | 1 | Write strobe, polarity per configuration |
| host_din_i | input | 32 | Write data from host |
| host_dout_o | output | 32 | Read data to host |
| host_doe_o | output | 1 | Read data drive enable |
| host_waitn_o | output | 1 | Wait, low stretches the current read |
| host_word_n_o | output | 1 | Wide data-port access indication, active low |
| irq_o | output | 1 | Interrupt, polarity per configuration |
| strap_wake_i | input | 1 | Width strap, upper bit |
| strap_eedo_i | input | 1 | Width strap, lower bit |
| cfg_strobe_inv_i | input | 1 | 1 makes strobes active high |
| cfg_irq_inv_i | input | 1 | 1 makes the interrupt active low |
| base_sel_i | input | 3 | Chooses one of eight base addresses |
| irq_src_i | input | 1 | Stub interrupt source |

## Verification
The bench checks the address decode at every boundary. It uses neighbouring bases, an address with bit 7 set, and a base selection moved away from 0x300. A decoder that ignored a bit would let a stray write change a register that is read back later. It measures the wait pulse on every read, so an off-by-one latency shows up as a wrong low count. It also runs reset with each strap combination and with inverted polarities. A design that mapped the reserved code wrongly, or re-sampled the straps after reset, would report the wrong status code or mask data to the wrong width.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned HP_DW = 32;
  localparam int unsigned HP_IW = 8;

  typedef enum logic [1:0] {
    WID_16  = 2'b00,
    WID_32  = 2'b01,
    WID_8   = 2'b10,
    WID_RSV = 2'b11
  } wid_e;

  // reserved strap setting falls back to the narrowest path
  function automatic wid_e wid_from_straps(input logic wake, input logic eedo);
    logic [1:0] code;
    code = {wake, eedo};
    if (code == 2'b11) return WID_8;
    return wid_e'(code);
  endfunction

  function automatic logic [HP_DW-1:0] wid_mask(input wid_e w, input logic [HP_DW-1:0] d);
    case (w)
      WID_8:   return {{(HP_DW-8){1'b0}}, d[7:0]};
      WID_16:  return {{(HP_DW-16){1'b0}}, d[15:0]};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/hp_strobe_sync.sv
module hp_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic lvl_o,
  output logic prev_o
);
  localparam int unsigned SW = STAGES + 1;

  logic [SW-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[SW-2:0], act_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign prev_o = sh_q[STAGES];
endmodule

// File: rtl/hp_decode.sv
module hp_decode #(
  parameter int unsigned ABITS  = 6,
  parameter logic [2:0]  HI_PAT = 3'b110
) (
  input  logic [ABITS-1:0] addr_i,
  input  logic [ABITS-4:0] base_sel_i,
  input  logic             csn_i,
  output logic             hit_o
);
  localparam int unsigned LO_W = ABITS - 3;

  logic hi_ok, lo_ok;

  always_comb begin
    hi_ok = (addr_i[ABITS-1 -: 3] == HI_PAT);
    lo_ok = (addr_i[LO_W-1:0] == base_sel_i);
    hit_o = !csn_i && hi_ok && lo_ok;
  end
endmodule

// File: rtl/hp_regfile.sv
module hp_regfile
  import hp_pkg::*;
#(
  parameter int unsigned      NREG     = 16,
  parameter logic [HP_IW-1:0] STAT_IDX = 8'hFE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [HP_IW-1:0] wr_idx_i,
  input  logic [HP_DW-1:0] wr_data_i,
  input  logic [HP_IW-1:0] rd_idx_i,
  output logic [HP_DW-1:0] rd_data_o,
  input  wid_e             wid_i,
  input  logic             irq_src_i,
  output logic             pend_o
);
  logic [HP_DW-1:0] regs_q [NREG];
  logic             pend_q, pend_d;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic we;
    assign we = wr_en_i && (wr_idx_i == HP_IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_q[g] <= '0;
      else if (we)  regs_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (wr_en_i && (wr_idx_i == STAT_IDX) && wr_data_i[0]) pend_d = 1'b0;
    if (irq_src_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx_i == HP_IW'(i)) rd_data_o = regs_q[i];
    end
    if (rd_idx_i == STAT_IDX)
      rd_data_o = {{(HP_DW-8){1'b0}}, wid_i, 5'b0, pend_q};
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/idx_host_slave.sv
module idx_host_slave
  import hp_pkg::*;
#(
  parameter int unsigned ABITS    = 6,
  parameter int unsigned NREG     = 16,
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ABITS-1:0] host_addr_i,
  input  logic             host_csn_i,
  input  logic             host_cmd_i,
  input  logic             host_rd_i,
  input  logic             host_wr_i,
  input  logic [HP_DW-1:0] host_din_i,
  output logic [HP_DW-1:0] host_dout_o,
  output logic             host_doe_o,
  output logic             host_waitn_o,
  output logic             host_word_n_o,
  output logic             irq_o,
  input  logic             strap_wake_i,
  input  logic             strap_eedo_i,
  input  logic             cfg_strobe_inv_i,
  input  logic             cfg_irq_inv_i,
  input  logic [ABITS-4:0] base_sel_i,
  input  logic             irq_src_i
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       core_rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  // one-time strap and configuration sampling
  logic taken_q, taken_d, sinv_q, sinv_d, iinv_q, iinv_d;
  wid_e wid_q, wid_d;

  always_comb begin
    taken_d = taken_q;
    wid_d   = wid_q;
    sinv_d  = sinv_q;
    iinv_d  = iinv_q;
    if (!taken_q) begin
      taken_d = 1'b1;
      wid_d   = wid_from_straps(strap_wake_i, strap_eedo_i);
      sinv_d  = cfg_strobe_inv_i;
      iinv_d  = cfg_irq_inv_i;
    end
  end

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      taken_q <= 1'b0;
      wid_q   <= WID_8;
      sinv_q  <= 1'b0;
      iinv_q  <= 1'b0;
    end else begin
      taken_q <= taken_d;
      wid_q   <= wid_d;
      sinv_q  <= sinv_d;
      iinv_q  <= iinv_d;
    end
  end

  // strobe normalisation and synchronisation
  logic rd_act, wr_act;
  logic r_lvl, r_prev, w_lvl, w_prev;
  logic r_lead, w_trail;

  assign rd_act = taken_q & (host_rd_i ^ ~sinv_q);
  assign wr_act = taken_q & (host_wr_i ^ ~sinv_q);

  hp_strobe_sync #(.STAGES(2)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(core_rst_n), .act_i(rd_act), .lvl_o(r_lvl), .prev_o(r_prev));
  hp_strobe_sync #(.STAGES(2)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(core_rst_n), .act_i(wr_act), .lvl_o(w_lvl), .prev_o(w_prev));

  assign r_lead  = r_lvl & ~r_prev;
  assign w_trail = ~w_lvl & w_prev;

  logic hit;
  hp_decode #(.ABITS(ABITS), .HI_PAT(3'b110)) u_dec (
    .addr_i(host_addr_i), .base_sel_i(base_sel_i), .csn_i(host_csn_i), .hit_o(hit));

  // write capture while the synchronised strobe is active
  logic             cap_hit_q, cap_hit_d, cap_cmd_q, cap_cmd_d;
  logic [HP_DW-1:0] cap_din_q, cap_din_d;
  logic [HP_IW-1:0] idx_q, idx_d;
  logic             rf_we;
  logic [HP_DW-1:0] rf_wdata, rf_rdata;
  logic             pend;

  // read wait sequencing
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             waitn_q, waitn_d, rcmd_q, rcmd_d;
  logic [HP_DW-1:0] dout_q, dout_d, rd_val;

  always_comb begin
    cap_hit_d = cap_hit_q;
    cap_cmd_d = cap_cmd_q;
    cap_din_d = cap_din_q;
    if (w_lvl) begin
      cap_hit_d = hit;
      cap_cmd_d = host_cmd_i;
      cap_din_d = host_din_i;
    end
    idx_d = idx_q;
    if (w_trail && cap_hit_q && !cap_cmd_q) idx_d = cap_din_q[HP_IW-1:0];
    rf_we    = w_trail && cap_hit_q && cap_cmd_q;
    rf_wdata = wid_mask(wid_q, cap_din_q);
  end

  always_comb begin
    rd_val  = rcmd_q ? wid_mask(wid_q, rf_rdata) : {{(HP_DW-HP_IW){1'b0}}, idx_q};
    cnt_d   = cnt_q;
    waitn_d = waitn_q;
    rcmd_d  = rcmd_q;
    dout_d  = dout_q;
    if (r_lead && hit) begin
      cnt_d   = CW'(WAIT_CYC);
      waitn_d = 1'b0;
      rcmd_d  = host_cmd_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        waitn_d = 1'b1;
        dout_d  = rd_val;
      end
    end
  end

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cap_hit_q <= 1'b0;
      cap_cmd_q <= 1'b0;
      cap_din_q <= '0;
      idx_q     <= '0;
      cnt_q     <= '0;
      waitn_q   <= 1'b1;
      rcmd_q    <= 1'b0;
      dout_q    <= '0;
    end else begin
      cap_hit_q <= cap_hit_d;
      cap_cmd_q <= cap_cmd_d;
      cap_din_q <= cap_din_d;
      idx_q     <= idx_d;
      cnt_q     <= cnt_d;
      waitn_q   <= waitn_d;
      rcmd_q    <= rcmd_d;
      dout_q    <= dout_d;
    end
  end

  hp_regfile #(.NREG(NREG), .STAT_IDX(8'hFE)) u_rf (
    .clk_i(clk_i), .rst_ni(core_rst_n), .wr_en_i(rf_we), .wr_idx_i(idx_q),
    .wr_data_i(rf_wdata), .rd_idx_i(idx_q), .rd_data_o(rf_rdata),
    .wid_i(wid_q), .irq_src_i(irq_src_i), .pend_o(pend));

  assign host_dout_o   = dout_q;
  assign host_waitn_o  = waitn_q;
  assign host_doe_o    = hit & rd_act & r_lvl;
  assign host_word_n_o = ~(hit & host_cmd_i & (wid_q != WID_8));
  assign irq_o         = pend ^ iinv_q;
endmodule

// File: rtl/idx_host_slave_chk.sv
module idx_host_slave_chk
  import hp_pkg::*;
(
  input logic clk_i,
  input logic core_rst_n,
  input logic host_csn_i,
  input logic host_waitn_o,
  input logic host_word_n_o,
  input logic host_doe_o,
  input logic irq_o,
  input logic irq_src_i,
  input logic iinv_q,
  input logic taken_q,
  input wid_e wid_q
);
  // R7
  wait_two_low_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    $fell(host_waitn_o) |=> !host_waitn_o);
  // R7
  wait_release_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (!host_waitn_o && $past(!host_waitn_o)) |=> host_waitn_o);
  // R2
  idle_word_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    host_csn_i |-> host_word_n_o);
  // R2
  idle_doe_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    host_csn_i |-> !host_doe_o);
  // R11
  width_hold_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (taken_q && $past(taken_q)) |-> $stable(wid_q));
  // R10
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    $past(irq_src_i) |-> (irq_o != iinv_q));
endmodule

bind idx_host_slave idx_host_slave_chk u_chk (
  .clk_i(clk_i), .core_rst_n(core_rst_n), .host_csn_i(host_csn_i),
  .host_waitn_o(host_waitn_o), .host_word_n_o(host_word_n_o),
  .host_doe_o(host_doe_o), .irq_o(irq_o), .irq_src_i(irq_src_i),
  .iinv_q(iinv_q), .taken_q(taken_q), .wid_q(wid_q));

// File: tb/test_idx_host_slave.sv
module test_idx_host_slave;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        csn, cmd, rd, wr;
  logic [31:0] din;
  logic [31:0] dout;
  logic        doe, waitn, word_n, irq;
  logic        wake, eedo, sinv, iinv;
  logic [2:0]  base_sel;
  logic        irq_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side model state
  logic [31:0] mreg [16];
  logic [7:0]  m_idx;
  logic        m_pend;
  int          m_wid;
  logic [1:0]  m_code;
  logic        m_sinv, m_iinv;
  bit          mon_en = 0;
  logic        m_rd_act = 0;
  logic        mq1, mq2, mq3;
  int          mcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_host_slave i_idx_host_slave (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_csn_i(csn),
    .host_cmd_i(cmd), .host_rd_i(rd), .host_wr_i(wr), .host_din_i(din),
    .host_dout_o(dout), .host_doe_o(doe), .host_waitn_o(waitn),
    .host_word_n_o(word_n), .irq_o(irq), .strap_wake_i(wake),
    .strap_eedo_i(eedo), .cfg_strobe_inv_i(sinv), .cfg_irq_inv_i(iinv),
    .base_sel_i(base_sel), .irq_src_i(irq_src));

  function automatic bit bhit(input logic [5:0] a, input logic c, input logic [2:0] b);
    return !c && (a[5:3] == 3'b110) && (a[2:0] == b);
  endfunction

  function automatic logic [31:0] bmask(input logic [31:0] d);
    if (m_wid == 8)  return d & 32'h0000_00FF;
    if (m_wid == 16) return d & 32'h0000_FFFF;
    return d;
  endfunction

  function automatic logic [31:0] exp_data();
    if (m_idx < 8'd16) return bmask(mreg[m_idx[3:0]]);
    if (m_idx == 8'hFE) return {24'b0, m_code, 5'b0, m_pend};
    return 32'h0;
  endfunction

  function automatic logic rawlvl(input logic act);
    return act ? m_sinv : ~m_sinv;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle model of wait and word indication, compared every clock
  always @(posedge clk) begin
    bit st;
    if (!mon_en) begin
      mq1 = 0; mq2 = 0; mq3 = 0; mcnt = 0;
    end else begin
      st = mq2 && !mq3 && bhit(addr, csn, base_sel);
      mq3 = mq2; mq2 = mq1; mq1 = m_rd_act;
      if (st) mcnt = 2;
      else if (mcnt > 0) mcnt--;
    end
  end

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (mon_en) begin
      check("R7 wait per-clock", {31'b0, waitn}, {31'b0, (mcnt == 0)});
      check("R9 word per-clock", {31'b0, word_n},
            {31'b0, !(bhit(addr, csn, base_sel) && cmd && m_wid != 8)});
    end
  end

  task automatic do_reset(input logic w, input logic e, input logic si, input logic ii);
    mon_en = 0;
    @(negedge clk);
    wake = w; eedo = e; sinv = si; iinv = ii;
    m_sinv = si; m_iinv = ii;
    m_rd_act = 0;
    rd = rawlvl(0); wr = rawlvl(0);
    csn = 1; cmd = 0; addr = 6'b110000; din = 0; irq_src = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 16; i++) mreg[i] = 0;
    m_idx = 0; m_pend = 0;
    case ({w, e})
      2'b00: begin m_wid = 16; m_code = 2'b00; end
      2'b01: begin m_wid = 32; m_code = 2'b01; end
      default: begin m_wid = 8; m_code = 2'b10; end
    endcase
    mon_en = 1;
  endtask

  task automatic bus_write(input logic [5:0] a, input logic c, input logic [31:0] d, input logic cs_n);
    @(negedge clk);
    addr = a; cmd = c; din = d; csn = cs_n;
    wr = rawlvl(1);
    repeat (3) @(negedge clk);
    wr = rawlvl(0);
    repeat (4) @(negedge clk);
    csn = 1;
    if (bhit(a, cs_n, base_sel)) begin
      if (!c) m_idx = d[7:0];
      else if (m_idx < 8'd16) mreg[m_idx[3:0]] = bmask(d);
      else if (m_idx == 8'hFE && d[0]) m_pend = 0;
    end
  endtask

  task automatic bus_read(input string tag, input logic [5:0] a, input logic c, output logic [31:0] q);
    int lows;
    logic wdn;
    lows = 0;
    @(negedge clk);
    addr = a; cmd = c; csn = 0;
    rd = rawlvl(1); m_rd_act = 1;
    wdn = word_n;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (!waitn) lows++;
      if (k == 4) begin
        check({tag, " R7 doe during read"}, {31'b0, doe}, {31'b0, bhit(a, 1'b0, base_sel)});
        wdn = word_n;
      end
    end
    if (bhit(a, 1'b0, base_sel)) check({tag, " R7 wait low cycles"}, lows, 2);
    else check({tag, " R1 no wait off-base"}, lows, 0);
    if (c && bhit(a, 1'b0, base_sel))
      check({tag, " R9 word indication"}, {31'b0, wdn}, {31'b0, (m_wid == 8)});
    q = dout;
    rd = rawlvl(0); m_rd_act = 0;
    repeat (4) @(negedge clk);
    csn = 1;
  endtask

  logic [31:0] q;

  initial begin
    base_sel = 3'd0;
    do_reset(0, 0, 0, 0);
    // reset state
    check("R2 reset waitn", {31'b0, waitn}, 32'd1);
    check("R2 reset word_n", {31'b0, word_n}, 32'd1);
    check("R2 reset doe", {31'b0, doe}, 32'd0);
    check("R10 reset irq", {31'b0, irq}, 32'd0);
    check("R7 reset dout", dout, 32'd0);

    // R3 index port round trip
    bus_write(6'b110000, 0, 32'h0000_0005, 0);
    bus_read("R3 index", 6'b110000, 0, q);
    check("R3 index readback", q, 32'h5);
    // R8 R5 data write, 16-bit mask
    bus_write(6'b110000, 1, 32'h1234_ABCD, 0);
    bus_read("R5 data16", 6'b110000, 1, q);
    check("R5 16-bit masked data", q, exp_data());
    check("R8 write committed", q, 32'h0000_ABCD);
    // R1 neighbour base and bit7 ignored
    bus_write(6'b110001, 1, 32'h0000_1111, 0);
    bus_write(6'b111000, 1, 32'h0000_2222, 0);
    // R2 csn high ignored
    bus_write(6'b110000, 1, 32'h0000_3333, 1);
    bus_read("R1 after strays", 6'b110000, 1, q);
    check("R1 R2 stray writes ignored", q, 32'h0000_ABCD);
    // R1 moved base
    base_sel = 3'd3;
    bus_write(6'b110011, 0, 32'h0000_0007, 0);
    bus_write(6'b110011, 1, 32'h0000_BEEF, 0);
    bus_read("R1 base 0x330", 6'b110011, 1, q);
    check("R1 base select 3", q, 32'h0000_BEEF);
    bus_read("R1 old base", 6'b110000, 1, q);
    base_sel = 3'd0;
    bus_read("R1 back to 0x300", 6'b110000, 0, q);
    check("R1 index held", q, 32'h7);
    // R12 unimplemented index
    bus_write(6'b110000, 0, 32'h0000_0040, 0);
    bus_write(6'b110000, 1, 32'h0000_5A5A, 0);
    bus_read("R12 hole", 6'b110000, 1, q);
    check("R12 hole reads zero", q, 32'h0);
    // R6 R10 status and interrupt
    bus_write(6'b110000, 0, 32'h0000_00FE, 0);
    bus_read("R6 status16", 6'b110000, 1, q);
    check("R6 status 16-bit", q, 32'h0000_0000);
    @(negedge clk); irq_src = 1; @(negedge clk); irq_src = 0; m_pend = 1;
    @(negedge clk);
    check("R10 irq raised", {31'b0, irq}, 32'd1);
    bus_read("R10 status pend", 6'b110000, 1, q);
    check("R10 pending bit", q, exp_data());
    bus_write(6'b110000, 1, 32'h0000_0001, 0);
    check("R10 irq cleared", {31'b0, irq}, 32'd0);

    // 32-bit mode
    do_reset(0, 1, 0, 0);
    bus_write(6'b110000, 0, 32'h0000_0003, 0);
    bus_write(6'b110000, 1, 32'hDEAD_BEEF, 0);
    bus_read("R5 data32", 6'b110000, 1, q);
    check("R5 32-bit full data", q, 32'hDEAD_BEEF);
    // R11 straps changed after reset
    wake = 1; eedo = 0;
    bus_write(6'b110000, 0, 32'h0000_00FE, 0);
    bus_read("R11 status", 6'b110000, 1, q);
    check("R6 R11 status 32-bit held", q, 32'h0000_0040);

    // 8-bit mode
    do_reset(1, 0, 0, 0);
    bus_write(6'b110000, 0, 32'h0000_0002, 0);
    bus_write(6'b110000, 1, 32'h1234_5678, 0);
    bus_read("R5 data8", 6'b110000, 1, q);
    check("R5 8-bit masked data", q, 32'h0000_0078);
    bus_write(6'b110000, 0, 32'h0000_00FE, 0);
    bus_read("R6 status8", 6'b110000, 1, q);
    check("R6 status 8-bit", q, 32'h0000_0080);

    // reserved straps
    do_reset(1, 1, 0, 0);
    bus_write(6'b110000, 0, 32'h0000_00FE, 0);
    bus_read("R6 reserved", 6'b110000, 1, q);
    check("R5 R6 reserved maps to 8-bit", q, 32'h0000_0080);

    // R4 inverted strobes, R10 inverted interrupt
    do_reset(0, 0, 1, 1);
    check("R10 inverted irq idle", {31'b0, irq}, 32'd1);
    bus_write(6'b110000, 0, 32'h0000_0009, 0);
    bus_write(6'b110000, 1, 32'h0000_C0DE, 0);
    bus_read("R4 active-high read", 6'b110000, 1, q);
    check("R4 active-high strobes", q, 32'h0000_C0DE);
    @(negedge clk); irq_src = 1; @(negedge clk); irq_src = 0;
    @(negedge clk);
    check("R10 inverted irq asserted", {31'b0, irq}, 32'd0);

    mon_en = 0;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule